// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the combinational datapath that an accumulator-style microcontroller core places between its operand fetch and its writeback. On every cycle it takes a 4-bit operation code, the accumulator, a second operand, and the current carry and auxiliary-carry flags. It returns the new accumulator value together with new carry, auxiliary-carry, overflow and parity bits.

Alongside the flag values it drives a three-bit write-enable mask. The surrounding core uses this mask to decide which status bits it commits. Parity is recomputed from every result and has no enable.

The unit covers binary add, add with carry, and subtract with borrow. It also covers decimal adjustment after a packed-BCD addition, bitwise AND/OR/XOR, clear and complement, plain and through-carry rotates in both directions, nibble exchange, and increment and decrement. Instruction decode, addressing, register banks and flag storage belong to the core around it.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on `op_i` are: 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 decimal adjust, 4 AND, 5 OR, 6 XOR, 7 clear, 8 complement, 9 rotate left, 10 rotate right, 11 rotate left through carry, 12 rotate right through carry, 13 nibble swap, 14 increment, 15 decrement. In `flag_we_o`, bit 2 enables carry, bit 1 enables auxiliary carry and bit 0 enables overflow. When a flag is not enabled, `cy_o` equals `cy_i`, `ac_o` equals `ac_i` and `ov_o` is 0.
- R2: Add and add-with-carry produce `acc_i + opnd_i` and `acc_i + opnd_i + cy_i` respectively, modulo 256. Carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3. The mask is 3'b111. Example: 0xF5 + 0x0B gives 0x00 with carry 1, auxiliary carry 1 and parity 0.
- R3: Subtract-with-borrow always produces `acc_i - opnd_i - cy_i` modulo 256. Carry is set when a borrow into bit 7 is needed, auxiliary carry is set when a borrow into bit 3 is needed, and the mask is 3'b111.
- R4: Overflow for add operations is set when both operands share a sign bit and the result's sign differs from it. For subtract it is set when the operands' signs differ and the result's sign differs from the accumulator's.
- R5: Decimal adjust first adds 0x06 when the low nibble exceeds 9 or `ac_i` is 1. It then adds 0x60 when the resulting high nibble exceeds 9 or the running carry is 1, where the running carry is `cy_i` ORed with any carry out of the first step. Example: 0x6C with both flags 0 becomes 0x72.
- R6: Decimal adjust enables only the carry flag (mask 3'b100). Its carry output is `cy_i` ORed with a carry out of either step, so an incoming carry is never cleared.
- R7: AND, OR, XOR, clear (result 0x00) and complement (bitwise inverse of `acc_i`) enable no flag.
- R8: Plain rotates move bit 7 into bit 0 (left) or bit 0 into bit 7 (right) and enable no flag.
- R9: Rotates through carry place the outgoing bit in `cy_o` and the old `cy_i` in the vacated bit, with mask 3'b100. Example: 0x9C rotated right with carry 0 gives 0x4E and carry 0. With carry 1 it gives 0xCE and carry 0.
- R10: Nibble swap exchanges bits 7..4 with bits 3..0 (0x5E becomes 0xE5) and enables no flag.
- R11: Increment and decrement wrap modulo 256 (0xFF+1 = 0x00, 0x00-1 = 0xFF) and enable no flag.
- R12: `par_o` is 1 exactly when the result holds an odd number of ones, for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (encoding in R1) |
| acc_i | input | DATA_W | Accumulator operand |
| opnd_i | input | DATA_W | Second operand |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| res_o | output | DATA_W | Operation result |
| cy_o | output | 1 | New carry value |
| ac_o | output | 1 | New auxiliary-carry value |
| ov_o | output | 1 | New overflow value |
| par_o | output | 1 | Parity of the result |
| flag_we_o | output | 3 | Flag write-enable mask {carry, aux, overflow} |

## Verification
The bench builds the unit with its default width of 8, which is the width the decimal-adjust rule and the flag positions are defined for. At this width every nibble boundary, the sign bit and the full 0x00/0xFF wrap points can be reached with directed operands.

An integer model in the bench covers all sixteen operation codes under a long pseudo-random sweep with both incoming flag values. It follows the directed cases: the worked addition, BCD and rotate examples, signed overflow on both sides, borrow chains through bit 3, and decimal-adjust inputs where the first correction carries out of the top bit.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W   = 4;
    localparam int NIB_W  = 4;
    localparam int BCD_MAX = 9;
    localparam int BCD_FIX = 6;
    localparam int FLG_N  = 3;

    // Flag write-enable bit positions
    localparam int WE_CY = 2;
    localparam int WE_AC = 1;
    localparam int WE_OV = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_DADJ = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_CLR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_ROLC = 4'd11,
        OP_RORC = 4'd12,
        OP_SWP  = 4'd13,
        OP_INC  = 4'd14,
        OP_DEC  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_ARITH = 2'd0,
        SRC_DADJ  = 2'd1,
        SRC_BITS  = 2'd2
    } res_src_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } flag_t;

    typedef struct packed {
        res_src_e           src;
        logic               use_carry_in;
        logic               subtract;
        logic [FLG_N-1:0]   we;
        logic               cy_from_bits;
    } op_ctl_t;

    function automatic op_ctl_t decode_op(input alu_op_e op);
        op_ctl_t c;
        c.src          = SRC_BITS;
        c.use_carry_in = 1'b0;
        c.subtract     = 1'b0;
        c.we           = '0;
        c.cy_from_bits = 1'b0;
        unique case (op)
            OP_ADD: begin
                c.src = SRC_ARITH;
                c.we  = 3'b111;
            end
            OP_ADDC: begin
                c.src          = SRC_ARITH;
                c.use_carry_in = 1'b1;
                c.we           = 3'b111;
            end
            OP_SUBB: begin
                c.src          = SRC_ARITH;
                c.use_carry_in = 1'b1;
                c.subtract     = 1'b1;
                c.we           = 3'b111;
            end
            OP_DADJ: begin
                c.src          = SRC_DADJ;
                c.we[WE_CY]    = 1'b1;
            end
            OP_ROLC, OP_RORC: begin
                c.we[WE_CY]    = 1'b1;
                c.cy_from_bits = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output flag_t             flg_o
);
    localparam int SUM_W = DATA_W + 1;
    localparam int LOW_W = NIB_W + 1;

    logic [DATA_W-1:0] b_eff;
    logic              cin_eff;
    logic [SUM_W-1:0]  full_sum;
    logic [LOW_W-1:0]  low_sum;
    logic              msb_a;
    logic              msb_b;
    logic              msb_r;

    // Subtraction as a + ~b + ~borrow; the carry outputs invert to borrows.
    assign b_eff   = sub_i ? ~b_i : b_i;
    assign cin_eff = sub_i ? ~cin_i : cin_i;

    assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_eff};
    assign low_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                    + {{NIB_W{1'b0}}, cin_eff};

    assign sum_o = full_sum[DATA_W-1:0];

    assign msb_a = a_i[DATA_W-1];
    assign msb_b = b_eff[DATA_W-1];
    assign msb_r = full_sum[DATA_W-1];

    always_comb begin
        flg_o.cy = full_sum[DATA_W] ^ sub_i;
        flg_o.ac = low_sum[NIB_W] ^ sub_i;
        flg_o.ov = (msb_a == msb_b) && (msb_r != msb_a);
    end

endmodule

// File: rtl/acc_alu_dadj.sv
module acc_alu_dadj
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic              cy_i,
    input  logic              ac_i,
    output logic [DATA_W-1:0] val_o,
    output logic              cy_o
);
    localparam int DIGITS = DATA_W / NIB_W;
    localparam int EXT_W  = DATA_W + 1;

    logic [DIGITS:0][DATA_W-1:0] stage_val;
    logic [DIGITS:0]             stage_cy;

    assign stage_val[0] = val_i;
    assign stage_cy[0]  = cy_i;

    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        localparam int LSB = k * NIB_W;
        localparam logic [EXT_W-1:0] FIX = EXT_W'(BCD_FIX) << LSB;

        logic [NIB_W-1:0] digit;
        logic             force_fix;
        logic             need_fix;
        logic [EXT_W-1:0] adj;

        assign digit = stage_val[k][LSB +: NIB_W];

        // Lowest digit follows the aux flag, top digit the running carry.
        if (k == 0) begin : g_low
            assign force_fix = ac_i;
        end else if (k == DIGITS - 1) begin : g_top
            assign force_fix = stage_cy[k];
        end else begin : g_mid
            assign force_fix = 1'b0;
        end

        assign need_fix = (digit > NIB_W'(BCD_MAX)) || force_fix;
        assign adj      = {1'b0, stage_val[k]} + (need_fix ? FIX : '0);

        assign stage_val[k+1] = adj[DATA_W-1:0];
        assign stage_cy[k+1]  = stage_cy[k] | adj[DATA_W];
    end

    assign val_o = stage_val[DIGITS];
    assign cy_o  = stage_cy[DIGITS];

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] rol_v;
    logic [DATA_W-1:0] ror_v;
    logic [DATA_W-1:0] rolc_v;
    logic [DATA_W-1:0] rorc_v;
    logic [DATA_W-1:0] swp_v;
    logic [DATA_W-1:0] inc_v;
    logic [DATA_W-1:0] dec_v;

    assign rol_v  = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
    assign ror_v  = {a_i[0], a_i[DATA_W-1:1]};
    assign rolc_v = {a_i[DATA_W-2:0], cin_i};
    assign rorc_v = {cin_i, a_i[DATA_W-1:1]};
    assign swp_v  = {a_i[HALF-1:0], a_i[DATA_W-1:HALF]};
    assign inc_v  = a_i + DATA_W'(1);
    assign dec_v  = a_i - DATA_W'(1);

    always_comb begin
        res_o  = a_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_CLR:  res_o = '0;
            OP_CPL:  res_o = ~a_i;
            OP_ROL:  res_o = rol_v;
            OP_ROR:  res_o = ror_v;
            OP_ROLC: begin
                res_o  = rolc_v;
                cout_o = a_i[DATA_W-1];
            end
            OP_RORC: begin
                res_o  = rorc_v;
                cout_o = a_i[0];
            end
            OP_SWP:  res_o = swp_v;
            OP_INC:  res_o = inc_v;
            OP_DEC:  res_o = dec_v;
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              cy_i,
    input  logic              ac_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o,
    output logic              par_o,
    output logic [2:0]        flag_we_o
);
    alu_op_e           op;
    op_ctl_t           ctl;

    logic [DATA_W-1:0] arith_res;
    flag_t             arith_flg;
    logic [DATA_W-1:0] dadj_res;
    logic              dadj_cy;
    logic [DATA_W-1:0] bits_res;
    logic              bits_cy;
    logic              cin_arith;

    assign op        = alu_op_e'(op_i);
    assign ctl       = decode_op(op);
    assign cin_arith = ctl.use_carry_in & cy_i;

    acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .cin_i (cin_arith),
        .sub_i (ctl.subtract),
        .sum_o (arith_res),
        .flg_o (arith_flg)
    );

    acc_alu_dadj #(.DATA_W(DATA_W)) u_dadj (
        .val_i (acc_i),
        .cy_i  (cy_i),
        .ac_i  (ac_i),
        .val_o (dadj_res),
        .cy_o  (dadj_cy)
    );

    acc_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op_i   (op),
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .cin_i  (cy_i),
        .res_o  (bits_res),
        .cout_o (bits_cy)
    );

    always_comb begin
        flag_t nxt;
        nxt.cy = cy_i;
        nxt.ac = ac_i;
        nxt.ov = 1'b0;
        res_o  = bits_res;
        unique case (ctl.src)
            SRC_ARITH: begin
                res_o = arith_res;
                nxt   = arith_flg;
            end
            SRC_DADJ: begin
                res_o  = dadj_res;
                nxt.cy = dadj_cy;
            end
            default: begin
                res_o = bits_res;
                if (ctl.cy_from_bits) begin
                    nxt.cy = bits_cy;
                end
            end
        endcase
        cy_o = ctl.we[WE_CY] ? nxt.cy : cy_i;
        ac_o = ctl.we[WE_AC] ? nxt.ac : ac_i;
        ov_o = ctl.we[WE_OV] ? nxt.ov : 1'b0;
    end

    assign flag_we_o = ctl.we;
    assign par_o     = ^res_o;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int DATA_W = 8
) (
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic              cy_i,
    input logic              ac_i,
    input logic [DATA_W-1:0] res_o,
    input logic              cy_o,
    input logic              ac_o,
    input logic              ov_o,
    input logic              par_o,
    input logic [2:0]        flag_we_o
);
    logic [DATA_W:0] add_ref;
    assign add_ref = {1'b0, acc_i} + {1'b0, opnd_i};

    always_comb begin
        // R2
        add_sum_chk: assert (op_i != 4'd0 || {cy_o, res_o} == add_ref)
            else $error("add sum/carry mismatch");
        // R6
        dadj_keep_cy_chk: assert (op_i != 4'd3 || !cy_i || cy_o)
            else $error("decimal adjust cleared carry");
        // R6
        dadj_mask_chk: assert (op_i != 4'd3 || flag_we_o == 3'b100)
            else $error("decimal adjust mask");
        // R7
        logic_no_flag_chk: assert (!(op_i >= 4'd4 && op_i <= 4'd8) || flag_we_o == 3'b000)
            else $error("logic op enabled a flag");
        // R7
        clr_zero_chk: assert (op_i != 4'd7 || (res_o == '0 && par_o == 1'b0))
            else $error("clear result");
        // R9
        rlc_out_chk: assert (op_i != 4'd11 || (cy_o == acc_i[DATA_W-1] && res_o[0] == cy_i))
            else $error("rotate left through carry");
        // R11
        incdec_no_flag_chk: assert (op_i < 4'd14 || (flag_we_o == 3'b000 && cy_o == cy_i && ac_o == ac_i && !ov_o))
            else $error("inc/dec touched a flag");
        // R1
        ov_off_chk: assert (flag_we_o[0] || !ov_o)
            else $error("overflow asserted while not enabled");
    end
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .op_i      (op_i),
    .acc_i     (acc_i),
    .opnd_i    (opnd_i),
    .cy_i      (cy_i),
    .ac_i      (ac_i),
    .res_o     (res_o),
    .cy_o      (cy_o),
    .ac_o      (ac_o),
    .ov_o      (ov_o),
    .par_o     (par_o),
    .flag_we_o (flag_we_o)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op = '0;
    logic [W-1:0] acc = '0;
    logic [W-1:0] opnd = '0;
    logic         cy = 1'b0;
    logic         ac = 1'b0;
    logic [W-1:0] res;
    logic         cy_o, ac_o, ov_o, par_o;
    logic [2:0]   we;

    int runs  = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    acc_alu #(.DATA_W(W)) u_dut (
        .op_i(op), .acc_i(acc), .opnd_i(opnd), .cy_i(cy), .ac_i(ac),
        .res_o(res), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .par_o(par_o),
        .flag_we_o(we)
    );

    function automatic string tag_of(input int o);
        case (o)
            0, 1:   return "R2";
            2:      return "R3";
            3:      return "R5";
            4, 5, 6, 7, 8: return "R7";
            9, 10:  return "R8";
            11, 12: return "R9";
            13:     return "R10";
            default: return "R11";
        endcase
    endfunction

    // Behavioural model from the requirements; packs {res,cy,ac,ov,par,we}.
    function automatic int model(input int o, input int a, input int b,
                                 input int c, input int x);
        int r = 0, fc = c, fa = x, fo = 0, w = 0, s, ones;
        case (o)
            0, 1: begin
                int ci = (o == 1) ? c : 0;
                s  = a + b + ci;
                r  = s % 256;
                fc = (s > 255);
                fa = ((a % 16) + (b % 16) + ci) > 15;
                fo = ((a >= 128) == (b >= 128)) && ((r >= 128) != (a >= 128));
                w  = 7;
            end
            2: begin
                s  = a - b - c;
                r  = (s + 256) % 256;
                fc = (s < 0);
                fa = ((a % 16) - (b % 16) - c) < 0;
                fo = ((a >= 128) != (b >= 128)) && ((r >= 128) != (a >= 128));
                w  = 7;
            end
            3: begin
                int v = a, rc = c;
                if ((v % 16) > 9 || x == 1) begin
                    v = v + 6;
                    if (v > 255) begin rc = 1; v = v - 256; end
                end
                if ((v / 16) > 9 || rc == 1) begin
                    v = v + 96;
                    if (v > 255) begin rc = 1; v = v - 256; end
                end
                r = v; fc = rc; w = 4;
            end
            4:  r = a & b;
            5:  r = a | b;
            6:  r = a ^ b;
            7:  r = 0;
            8:  r = 255 - a;
            9:  r = ((a * 2) % 256) + (a / 128);
            10: r = (a / 2) + (a % 2) * 128;
            11: begin r = ((a * 2) % 256) + c; fc = a / 128; w = 4; end
            12: begin r = (a / 2) + c * 128;   fc = a % 2;   w = 4; end
            13: r = (a % 16) * 16 + (a / 16);
            14: r = (a + 1) % 256;
            default: r = (a + 255) % 256;
        endcase
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        return (r << 7) | (fc << 6) | (fa << 5) | (fo << 4) | ((ones % 2) << 3) | w;
    endfunction

    task automatic apply(input int o, input int a, input int b, input int c,
                         input int x, input string tag);
        int exp_v, act_v;
        @(posedge clk);
        #1;
        op = 4'(o); acc = 8'(a); opnd = 8'(b); cy = c[0]; ac = x[0];
        #2;
        exp_v = model(o, a, b, c, x);
        act_v = {17'd0, res, cy_o, ac_o, ov_o, par_o, we};
        runs++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s op=%0d a=%02h b=%02h c=%0d ac=%0d: got res=%02h cy=%0d ac=%0d ov=%0d p=%0d we=%03b, exp res=%02h cy=%0d ac=%0d ov=%0d p=%0d we=%03b",
                     tag, o, a, b, c, x, act_v >> 7, act_v[6], act_v[5], act_v[4], act_v[3], act_v[2:0],
                     exp_v >> 7, exp_v[6], exp_v[5], exp_v[4], exp_v[3], exp_v[2:0]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            runs++; fails++;
            $display("FAIL R1 watchdog expired: got running, exp finished");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R2 quiescent state: all-zero inputs
        apply(0, 8'h00, 8'h00, 0, 0, "R2 reset-state");
        // R2 worked example and R12 parity on zero
        apply(0, 8'hF5, 8'h0B, 0, 0, "R2 F5+0B");
        apply(1, 8'hE7, 8'h8D, 1, 0, "R2 addc");
        apply(1, 8'h3C, 8'h3B, 1, 1, "R2 addc hi");
        // R4 signed overflow both ways
        apply(0, 8'h7F, 8'h01, 0, 0, "R4 pos ovf");
        apply(0, 8'h80, 8'hFF, 0, 0, "R4 neg ovf");
        apply(2, 8'h80, 8'h01, 0, 0, "R4 sub ovf");
        apply(2, 8'h7F, 8'hFF, 0, 0, "R4 sub ovf2");
        // R3 borrow chains
        apply(2, 8'h10, 8'h01, 0, 0, "R3 aux borrow");
        apply(2, 8'h00, 8'h00, 1, 0, "R3 borrow in");
        apply(2, 8'h55, 8'h55, 0, 1, "R3 zero");
        // R5 / R6 decimal adjust
        apply(3, 8'h6C, 8'h00, 0, 0, "R5 47+25");
        apply(3, 8'h12, 8'h00, 0, 1, "R5 aux forced");
        apply(3, 8'hFA, 8'h00, 0, 0, "R5 first-step carry");
        apply(3, 8'h33, 8'h00, 1, 0, "R6 carry kept");
        apply(3, 8'hA0, 8'h00, 0, 0, "R6 high fix");
        // R7 logic group
        apply(4, 8'h97, 8'hF2, 1, 1, "R7 and");
        apply(5, 8'h97, 8'hF2, 0, 1, "R7 or");
        apply(6, 8'h97, 8'hF2, 1, 0, "R7 xor");
        apply(7, 8'hA5, 8'h00, 1, 1, "R7 clr");
        apply(8, 8'hA5, 8'h00, 0, 0, "R7 cpl");
        // R8 / R9 rotates
        apply(9,  8'h9C, 8'h00, 1, 0, "R8 rl");
        apply(10, 8'h9C, 8'h00, 0, 1, "R8 rr");
        apply(12, 8'h9C, 8'h00, 0, 0, "R9 rrc c0");
        apply(12, 8'h9C, 8'h00, 1, 0, "R9 rrc c1");
        apply(11, 8'h9C, 8'h00, 1, 1, "R9 rlc");
        // R10 swap
        apply(13, 8'h5E, 8'h00, 0, 0, "R10 swap");
        // R11 wrap points
        apply(14, 8'hFF, 8'h00, 1, 1, "R11 inc wrap");
        apply(15, 8'h00, 8'h00, 0, 1, "R11 dec wrap");
        // R12 parity across a pseudo-random sweep of every opcode
        for (int n = 0; n < 4000; n++) begin
            int o;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            o  = n % 16;
            apply(o, int'(lf[7:0]), int'(lf[15:8] ^ lf[7:0]), int'(lf[3]), int'(lf[9]),
                  {tag_of(o), "/R12 sweep"});
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule